// File: doc/BRIEF.md
# Three-Bus Datapath with PC Incrementer

This block is a small processor core built around three internal buses. A register file has two read ports and one write port, and all three can be used in the same cycle. The first read port drives bus A into the ALU's first input and the second drives bus B into its second input. Bus C carries the ALU result, or the memory data register, back to the write port. The program counter has its own incrementer, so the ALU never spends a step on advancing it and its first input needs no constant-select multiplexer.

A step counter sequences every instruction. Step 1 loads the memory address register from the PC. Step 2 reads memory into the memory data register while the incrementer advances the PC. Step 3 moves the fetched word into the instruction register. The instruction is decoded at the start of step 4. Add and subtract finish in that step, with both operands and the result moving in parallel, and the counter then returns to step 1. A load instruction goes on through the address and data registers. In step 4 it sends a register through bus A into the address register, in step 5 it reads memory, and in step 6 it writes the data register into the destination over bus C. The memory port reads combinationally, and the read word is captured at the end of the read step.

Top module: `tribus_core`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it, `step_o` is 1, `pc_o` is 0, and `rf_we_o` and `mem_rd_o` are 0. All registers in the file hold zero after reset.
- R2: In step 1, `mem_rd_o` is 0. In step 2, `mem_rd_o` is 1 and `mem_addr_o` equals the PC value shown during step 1.
- R3: `step_o` moves 1 → 2 → 3 → 4 on consecutive cycles for every instruction.
- R4: The PC grows by `INC_STEP`, modulo 2^AW, at the end of step 2 only, so `pc_o` shows the new value from step 3 onward. It holds its value in every other step.
- R5: Instruction word layout:
  - Bits [15:14] hold the opcode: 00 add, 01 subtract, 10 load, 11 no-op.
  - Bits [13:11] hold the destination register.
  - Bits [10:8] hold the first source.
  - Bits [7:5] hold the second source.
  - Bits [4:0] are ignored.

  For add, step 4 shows `rf_we_o`=1, `rf_waddr_o`=destination, and `rf_wdata_o` = src1 + src2 modulo 2^16. This holds even when all three fields name the same register.
- R6: For subtract, step 4 shows `rf_we_o`=1 with `rf_wdata_o` = src1 − src2 modulo 2^16.
- R7: After step 4 of an add, subtract or no-op, the next cycle is step 1 of the next instruction.
- R8: A value written in step 4 or step 6 is the value read by any later instruction that sources that register.
- R9: For a load, step 4 has no write. Step 5 shows `mem_rd_o`=1 with `mem_addr_o` equal to the low AW bits of src1. Step 6 writes the word read in step 5 into the destination. Step 1 follows.
- R10: A no-op writes nothing in step 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | AW | Memory address from the address register |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | DW | Memory read data, captured at the end of a read step |
| pc_o | output | AW | Program counter |
| step_o | output | 3 | Current control step (1 to 6) |
| rf_we_o | output | 1 | Register-file write enable (bus C write) |
| rf_waddr_o | output | RW | Register-file write index |
| rf_wdata_o | output | DW | Value on bus C |

## Verification
A directed prefix comes first. It loads a register from address zero while the file is still at reset, doubles that register with the same register as destination and both sources, so the high bit carries out, and subtracts it from zero so the result underflows. It then adds the result to itself, runs a no-op, and loads through the computed address. These cases separate parallel port use, wrap-around arithmetic and write-then-read visibility from the ordinary sum. A random program with mixed opcodes and register indices then runs through PC wrap-around. Each step of each instruction is checked against a bench model of the register file, which tells a wrong step order, a misplaced PC increment, a bad operand index and a wrong bus C source apart.

// File: rtl/tribus_pkg.sv
package tribus_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_LOAD = 2'b10,
    OP_NOP  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_READ  = 3'd2,
    ST_IR    = 3'd3,
    ST_EXEC  = 3'd4,
    ST_MREAD = 3'd5,
    ST_WBACK = 3'd6
  } step_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_a;
    logic mem_rd;
    logic mdr_load;
    logic ir_load;
    logic pc_inc;
    logic rf_we;
    logic busc_mdr;
    logic alu_sub;
  } ctrl_t;

endpackage

// File: rtl/tribus_regfile.sv
module tribus_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] ra_i,
  input  logic [RW-1:0] rb_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o,
  input  logic          we_i,
  input  logic [RW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i
);

  logic [DW-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[ra_i];
  assign rdata_b_o = regs_q[rb_i];

  // write lands for reads one cycle later
  assert_wr_visible_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(waddr_i)] == $past(wdata_i));

endmodule

// File: rtl/tribus_alu.sv
module tribus_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  output logic [DW-1:0] y_o
);

  assign y_o = sub_i ? (a_i - b_i) : (a_i + b_i);

endmodule

// File: rtl/tribus_ctrl.sv
module tribus_ctrl
  import tribus_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  op_e   op_i,
  output step_e step_o,
  output ctrl_t ctrl_o
);

  step_e step_q, step_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= ST_ADDR;
    else         step_q <= step_d;
  end

  always_comb begin
    ctrl_o = '0;
    step_d = ST_ADDR;
    unique case (step_q)
      ST_ADDR: begin
        ctrl_o.mar_from_pc = 1'b1;
        step_d = ST_READ;
      end
      ST_READ: begin
        ctrl_o.mem_rd   = 1'b1;
        ctrl_o.mdr_load = 1'b1;
        ctrl_o.pc_inc   = 1'b1;
        step_d = ST_IR;
      end
      ST_IR: begin
        ctrl_o.ir_load = 1'b1;
        step_d = ST_EXEC;
      end
      ST_EXEC: begin
        unique case (op_i)
          OP_ADD:  ctrl_o.rf_we = 1'b1;
          OP_SUB: begin
            ctrl_o.rf_we   = 1'b1;
            ctrl_o.alu_sub = 1'b1;
          end
          OP_LOAD: begin
            ctrl_o.mar_from_a = 1'b1;
            step_d = ST_MREAD;
          end
          default: ;
        endcase
      end
      ST_MREAD: begin
        ctrl_o.mem_rd   = 1'b1;
        ctrl_o.mdr_load = 1'b1;
        step_d = ST_WBACK;
      end
      ST_WBACK: begin
        ctrl_o.rf_we    = 1'b1;
        ctrl_o.busc_mdr = 1'b1;
      end
      default: ;
    endcase
  end

  assign step_o = step_q;

  assert_fetch_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q == ST_ADDR |=> step_q == ST_READ);
  assert_fetch_b_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q == ST_READ |=> step_q == ST_IR);
  assert_fetch_c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q == ST_IR |=> step_q == ST_EXEC);
  assert_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_EXEC && op_i != OP_LOAD) |=> step_q == ST_ADDR);
  assert_load_seq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_EXEC && op_i == OP_LOAD) |=> step_q == ST_MREAD);
  assert_load_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q == ST_WBACK |=> step_q == ST_ADDR);

endmodule

// File: rtl/tribus_core.sv
module tribus_core
  import tribus_pkg::*;
#(
  parameter int DW       = 16,
  parameter int AW       = 8,
  parameter int NREG     = 8,
  parameter int INC_STEP = 1,
  localparam int RW      = $clog2(NREG),
  localparam int IRW     = 2 + 3 * RW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] pc_o,
  output logic [2:0]    step_o,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o
);

  logic [AW-1:0]  pc_q, mar_q;
  logic [DW-1:0]  mdr_q;
  logic [IRW-1:0] ir_q;
  logic [DW-1:0]  bus_a, bus_b, bus_c, alu_y;
  op_e            op;
  logic [RW-1:0]  rd, rs1, rs2;
  step_e          step;
  ctrl_t          ctl;

  assign op  = op_e'(ir_q[IRW-1 -: 2]);
  assign rd  = ir_q[IRW-3 -: RW];
  assign rs1 = ir_q[IRW-3-RW -: RW];
  assign rs2 = ir_q[IRW-3-2*RW -: RW];

  tribus_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .step_o (step),
    .ctrl_o (ctl)
  );

  tribus_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ra_i      (rs1),
    .rb_i      (rs2),
    .rdata_a_o (bus_a),
    .rdata_b_o (bus_b),
    .we_i      (ctl.rf_we),
    .waddr_i   (rd),
    .wdata_i   (bus_c)
  );

  tribus_alu #(.DW(DW)) u_alu (
    .a_i   (bus_a),
    .b_i   (bus_b),
    .sub_i (ctl.alu_sub),
    .y_o   (alu_y)
  );

  assign bus_c = ctl.busc_mdr ? mdr_q : alu_y;

  // dedicated incrementer; the ALU never touches the PC
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pc_q <= '0;
    else if (ctl.pc_inc) pc_q <= pc_q + AW'(INC_STEP);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              mar_q <= '0;
    else if (ctl.mar_from_pc) mar_q <= pc_q;
    else if (ctl.mar_from_a)  mar_q <= bus_a[AW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdr_q <= '0;
      ir_q  <= {2'b11, {(IRW-2){1'b0}}};
    end else begin
      if (ctl.mdr_load) mdr_q <= mem_rdata_i;
      if (ctl.ir_load)  ir_q  <= mdr_q[DW-1 -: IRW];
    end
  end

  assign mem_addr_o = mar_q;
  assign mem_rd_o   = ctl.mem_rd;
  assign pc_o       = pc_q;
  assign step_o     = step;
  assign rf_we_o    = ctl.rf_we;
  assign rf_waddr_o = rd;
  assign rf_wdata_o = bus_c;

  assert_fetch_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step == ST_ADDR |=> mem_addr_o == $past(pc_q));
  assert_pc_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step == ST_READ |=> pc_q == $past(pc_q) + AW'(INC_STEP));
  assert_pc_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step != ST_READ |=> $stable(pc_q));
  assert_load_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step == ST_EXEC && op == OP_LOAD) |=> mem_addr_o == $past(bus_a[AW-1:0]));
  assert_rd_steps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (step == ST_READ || step == ST_MREAD));

endmodule

// File: tb/tribus_core_bench.sv
module tribus_core_bench;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  mem_addr;
  logic        mem_rd;
  logic [15:0] mem_rdata;
  logic [7:0]  pc;
  logic [2:0]  step;
  logic        rf_we;
  logic [2:0]  rf_waddr;
  logic [15:0] rf_wdata;

  logic [15:0] mem [256];
  logic [15:0] regs [8];
  logic [7:0]  mpc;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign mem_rdata = mem[mem_addr];

  tribus_core u_tribus_core (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_rd_o    (mem_rd),
    .mem_rdata_i (mem_rdata),
    .pc_o        (pc),
    .step_o      (step),
    .rf_we_o     (rf_we),
    .rf_waddr_o  (rf_waddr),
    .rf_wdata_o  (rf_wdata)
  );

  function automatic logic [15:0] enc(input logic [1:0] op, input logic [2:0] d,
                                      input logic [2:0] s1, input logic [2:0] s2);
    return {op, d, s1, s2, 5'b0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (pc %0h)", req, act, exp, mpc);
    end
  endtask

  // called at a falling edge while the design is in step 1
  task automatic run_instr();
    logic [15:0] iw, exp;
    logic [1:0]  op;
    logic [2:0]  d, s1, s2;
    logic [7:0]  la;
    iw = mem[mpc];
    op = iw[15:14]; d = iw[13:11]; s1 = iw[10:8]; s2 = iw[7:5];
    check("R7 step1", step, 3'd1);
    check("R2 pc in step1", pc, mpc);
    check("R2 no read step1", mem_rd, 1'b0);
    @(negedge clk);
    check("R3 step2", step, 3'd2);
    check("R2 read strobe", mem_rd, 1'b1);
    check("R2 fetch addr", mem_addr, mpc);
    @(negedge clk);
    check("R3 step3", step, 3'd3);
    check("R4 pc advanced", pc, 8'(mpc + 8'd1));
    @(negedge clk);
    check("R3 step4", step, 3'd4);
    check("R4 pc held", pc, 8'(mpc + 8'd1));
    case (op)
      2'b00, 2'b01: begin
        exp = (op == 2'b00) ? regs[s1] + regs[s2] : regs[s1] - regs[s2];
        check(op == 2'b00 ? "R5 add we" : "R6 sub we", rf_we, 1'b1);
        check(op == 2'b00 ? "R5 add dest" : "R6 sub dest", rf_waddr, d);
        check(op == 2'b00 ? "R5 R8 add data" : "R6 R8 sub data", rf_wdata, exp);
        regs[d] = exp;
      end
      2'b10: begin
        check("R9 no write step4", rf_we, 1'b0);
        la = regs[s1][7:0];
        @(negedge clk);
        check("R9 step5", step, 3'd5);
        check("R9 read strobe", mem_rd, 1'b1);
        check("R9 R8 load addr", mem_addr, la);
        @(negedge clk);
        check("R9 step6", step, 3'd6);
        check("R9 we", rf_we, 1'b1);
        check("R9 dest", rf_waddr, d);
        check("R9 data", rf_wdata, mem[la]);
        regs[d] = mem[la];
      end
      default: check("R10 nop no write", rf_we, 1'b0);
    endcase
    mpc = mpc + 8'd1;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) regs[i] = '0;
    // directed corners first
    mem[0] = enc(2'b10, 3'd1, 3'd0, 3'd0); // load r1 from addr 0 (reset regs)
    mem[1] = enc(2'b00, 3'd1, 3'd1, 3'd1); // r1 = r1 + r1, carry out
    mem[2] = enc(2'b01, 3'd3, 3'd0, 3'd1); // r3 = 0 - r1, underflow
    mem[3] = enc(2'b00, 3'd4, 3'd3, 3'd3); // reads r3 just written
    mem[4] = enc(2'b11, 3'd5, 3'd1, 3'd2); // nop
    mem[5] = enc(2'b10, 3'd5, 3'd3, 3'd0); // load through computed address
    for (int a = 6; a < 256; a++)
      mem[a] = enc(2'($urandom_range(3, 0)), 3'($urandom_range(7, 0)),
                   3'($urandom_range(7, 0)), 3'($urandom_range(7, 0))) |
               16'($urandom_range(31, 0));
    mpc = '0;
    repeat (3) @(negedge clk);
    check("R1 reset step", step, 3'd1);
    check("R1 reset pc", pc, 8'd0);
    check("R1 reset we", rf_we, 1'b0);
    check("R1 reset rd", mem_rd, 1'b0);
    rst_ni = 1'b1;
    check("R1 step after reset", step, 3'd1);
    for (int n = 0; n < 400; n++) run_instr();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule